// File: doc/BRIEF.md
# Averaged-Period LED Blink Timer

This block drives a status LED that blinks at a rate derived from four stored configuration bytes. When the load strobe arrives, it takes the truncated mean of the bytes presented on its input and multiplies that mean by a fixed number of prescaled ticks per 10 ms unit. The product is the reload value of a down counter. The counter advances only on tick-enable pulses, and the LED inverts each time the counter expires. With the default setting of 234 ticks per unit on a tick of about 23.44 kHz, each step of the mean adds 10 ms to the interval.

The LED output is active low. A load lights the LED at once, and the first toggle comes one full interval later. A zero mean leaves the LED lit and starts no counting. The stop input is raised when host traffic for the device is seen. It freezes the LED and the counter until the next load.

The control is a four-state machine. DARK is the reset state. HOLD means lit with no toggling. BLINK means counting and toggling. HALT means frozen by a stop. The transitions are:

- load_zero: any state goes to HOLD on a load with a zero mean.
- load_run: any state goes to BLINK on a load with a non-zero mean.
- expire: BLINK stays in BLINK on an expiry, and the LED toggles.
- stop: any state goes to HALT on a stop.

A stop and a load in the same cycle take the stop.

Top module: `blink_period_timer`

## Requirements
- R1: After reset the LED output is 1 (dark), and tick pulses without a load leave it at 1.
- R2: The mean is the sum of the NUM_BYTES bytes, shifted right by log2(NUM_BYTES) and truncated to BYTE_W bits. Byte k sits at bits [k*BYTE_W +: BYTE_W] of the byte input. The bytes used are the ones present in the cycle the load is sampled.
- R3: The interval is the mean times TICKS_PER_UNIT tick pulses. After a load with a non-zero mean, the LED output equals (n / interval) mod 2 after n tick pulses.
- R4: In the cycle after a load is sampled (with stop low), the LED output is 0 (lit). No toggle occurs on the load cycle itself.
- R5: A load with a zero mean leaves the LED output at 0, and it never toggles for any number of ticks.
- R6: Cycles without a tick pulse change neither the count nor the LED.
- R7: While stopped, the LED keeps its level and ticks have no effect until the next load. When stop and load are sampled in the same cycle, the stop wins and the load is ignored.
- R8: A load during counting restarts the interval from the new bytes and relights the LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bytes_i | input | NUM_BYTES*BYTE_W | Stored configuration bytes; byte k at [k*BYTE_W +: BYTE_W] |
| load_i | input | 1 | Strobe: recompute the mean and restart blinking |
| stop_i | input | 1 | Host traffic seen: freeze blinking |
| tick_i | input | 1 | Prescaled tick enable |
| led_n_o | output | 1 | LED drive, active low |

## Verification
The bench builds the block with TICKS_PER_UNIT set to 3, keeping BYTE_W at 8 and NUM_BYTES at 4. Even a mean of 255 then gives an interval of only 765 ticks. This makes it possible to follow every tick of two full intervals across a sweep of byte sets. The sweep covers the extreme means, sums that truncate, and sums that fall to a zero mean. Stop, stop-with-load and mid-count reloads are tested at chosen points in the count.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [1:0] {
        ST_DARK  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_BLINK = 2'd2,
        ST_HALT  = 2'd3
    } blink_state_t;

endpackage

// File: rtl/byte_averager.sv
module byte_averager #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic [NUM_BYTES*BYTE_W-1:0] bytes_i,
    output logic [BYTE_W-1:0]           mean_o
);
    localparam int SHIFT = $clog2(NUM_BYTES);
    localparam int SUM_W = BYTE_W + SHIFT;

    logic [SUM_W-1:0] ext [NUM_BYTES];
    logic [SUM_W-1:0] sum;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_ext
        assign ext[k] = SUM_W'(bytes_i[k*BYTE_W +: BYTE_W]);
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NUM_BYTES; k++) begin
            sum = sum + ext[k];
        end
        mean_o = BYTE_W'(sum >> SHIFT);
    end

    // R2: the truncated mean never exceeds the sum divided by the count
    always_comb begin
        assert_mean_bound_R2: assert ((SUM_W'(mean_o) << SHIFT) <= sum);
    end

endmodule

// File: rtl/reload_scaler.sv
module reload_scaler #(
    parameter int BYTE_W         = 8,
    parameter int TICKS_PER_UNIT = 234,
    parameter int CNT_W          = 16
) (
    input  logic [BYTE_W-1:0] mean_i,
    output logic [CNT_W-1:0]  reload_o
);
    logic [CNT_W-1:0] part [BYTE_W];

    for (genvar b = 0; b < BYTE_W; b++) begin : g_part
        assign part[b] = mean_i[b] ? (CNT_W'(TICKS_PER_UNIT) << b) : '0;
    end

    always_comb begin
        reload_o = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            reload_o = reload_o + part[b];
        end
    end

endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;

    assign expire_o = run_i && tick_i && !start_i && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (start_i) begin
            cnt_q    <= reload_i;
            reload_q <= reload_i;
        end else if (run_i && tick_i) begin
            if (cnt_q == CNT_W'(1)) begin
                cnt_q <= reload_q;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // R6: without a tick or a start the count does not move
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !start_i) |=> $stable(cnt_q));

    // R3: while running the count is never zero
    assert_cnt_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q != '0));

endmodule

// File: rtl/blink_fsm.sv
module blink_fsm
    import blink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic stop_i,
    input  logic mean_zero_i,
    input  logic expire_i,
    output logic start_o,
    output logic run_o,
    output logic led_n_o
);
    blink_state_t state_q, state_d;
    logic         led_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DARK;
            led_n_o <= 1'b1;
        end else begin
            state_q <= state_d;
            led_n_o <= led_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        led_d   = led_n_o;
        start_o = 1'b0;
        run_o   = 1'b0;
        unique case (state_q)
            ST_DARK, ST_HOLD, ST_HALT: begin
                if (stop_i) begin
                    state_d = ST_HALT;
                end else if (load_i) begin
                    state_d = mean_zero_i ? ST_HOLD : ST_BLINK;
                    led_d   = 1'b0;
                    start_o = 1'b1;
                end
            end
            ST_BLINK: begin
                if (stop_i) begin
                    state_d = ST_HALT;
                end else if (load_i) begin
                    state_d = mean_zero_i ? ST_HOLD : ST_BLINK;
                    led_d   = 1'b0;
                    start_o = 1'b1;
                end else begin
                    run_o = 1'b1;
                    if (expire_i) begin
                        led_d = ~led_n_o;
                    end
                end
            end
            default: state_d = ST_DARK;
        endcase
    end

    assert_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DARK) |-> led_n_o);

    assert_lit_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !stop_i) |=> !led_n_o);

    assert_hold_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !led_n_o);

    assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> $stable(led_n_o));

    assert_led_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_n_o) |-> $past(expire_i || load_i));

endmodule

// File: rtl/blink_period_timer.sv
module blink_period_timer #(
    parameter int BYTE_W         = 8,
    parameter int NUM_BYTES      = 4,
    parameter int TICKS_PER_UNIT = 234
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BYTES*BYTE_W-1:0] cfg_bytes_i,
    input  logic                        load_i,
    input  logic                        stop_i,
    input  logic                        tick_i,
    output logic                        led_n_o
);
    localparam int MAX_RELOAD = ((1 << BYTE_W) - 1) * TICKS_PER_UNIT;
    localparam int CNT_W      = $clog2(MAX_RELOAD + 1);

    logic [BYTE_W-1:0] mean;
    logic [CNT_W-1:0]  reload;
    logic              start;
    logic              run;
    logic              expire;

    byte_averager #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_avg (
        .bytes_i (cfg_bytes_i),
        .mean_o  (mean)
    );

    reload_scaler #(
        .BYTE_W         (BYTE_W),
        .TICKS_PER_UNIT (TICKS_PER_UNIT),
        .CNT_W          (CNT_W)
    ) u_scale (
        .mean_i   (mean),
        .reload_o (reload)
    );

    interval_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .reload_i (reload),
        .run_i    (run),
        .tick_i   (tick_i),
        .expire_o (expire)
    );

    blink_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .stop_i      (stop_i),
        .mean_zero_i (mean == '0),
        .expire_i    (expire),
        .start_o     (start),
        .run_o       (run),
        .led_n_o     (led_n_o)
    );

endmodule

// File: tb/blink_period_timer_test.sv
module blink_period_timer_test;
    localparam int T = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bytes = '0;
    logic        load = 1'b0;
    logic        stop = 1'b0;
    logic        tick = 1'b0;
    logic        led_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    blink_period_timer #(.BYTE_W(8), .NUM_BYTES(4), .TICKS_PER_UNIT(T)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_bytes_i(bytes),
        .load_i(load), .stop_i(stop), .tick_i(tick), .led_n_o(led_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: led_n=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic set_bytes(input int b0, input int b1, input int b2, input int b3);
        bytes = {8'(b3), 8'(b2), 8'(b1), 8'(b0)};
    endtask

    function automatic int interval(input int b0, input int b1, input int b2, input int b3);
        return (((b0 + b1 + b2 + b3) / 4) % 256) * T;
    endfunction

    // one load pulse, then check lit (R4)
    task automatic do_load();
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        check("R4 lit after load", led_n, 1'b0);
    endtask

    // one tick cycle followed by one idle cycle (R6)
    task automatic tick_once();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic run_pattern(input int b0, input int b1, input int b2, input int b3);
        int r;
        set_bytes(b0, b1, b2, b3);
        r = interval(b0, b1, b2, b3);
        do_load();
        if (r == 0) begin
            for (int n = 1; n <= 40; n++) begin
                tick_once();
                check("R5 zero mean stays lit", led_n, 1'b0);
            end
        end else begin
            for (int n = 1; n <= 2 * r; n++) begin
                tick_once();
                check("R3/R2 toggle timing", led_n, 1'(((n / r) % 2)));
                @(negedge clk);
                check("R6 no change without tick", led_n, 1'(((n / r) % 2)));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 dark at reset", led_n, 1'b1);
        rst_n = 1'b1;
        for (int n = 0; n < 10; n++) tick_once();
        check("R1 ticks without load", led_n, 1'b1);

        // corner patterns
        run_pattern(0, 0, 0, 0);
        run_pattern(3, 0, 0, 0);        // sum 3 -> mean 0 (R2 truncation, R5)
        run_pattern(1, 1, 1, 0);        // sum 3 -> mean 0
        run_pattern(4, 0, 0, 0);        // mean 1
        run_pattern(2, 2, 2, 1);        // sum 7 -> mean 1
        run_pattern(15, 150, 100, 200); // sum 465 -> mean 116
        run_pattern(255, 255, 255, 255);
        run_pattern(0, 0, 0, 255);      // mean 63
        // sweep
        for (int i = 0; i < 16; i++) begin
            run_pattern((i * 29 + 7) % 256, (i * 71 + 13) % 256,
                        (i * 113 + 3) % 256, (i * 37 * i + 1) % 256);
        end

        // R7: stop mid-count, ticks ignored
        set_bytes(40, 40, 40, 40);      // interval 120
        do_load();
        for (int n = 0; n < 50; n++) tick_once();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        for (int n = 0; n < 200; n++) tick_once();
        check("R7 stopped stays lit", led_n, 1'b0);

        // R7: stop after a toggle keeps dark level; stop+load ignored
        set_bytes(4, 4, 0, 0);          // mean 2, interval 6
        do_load();
        for (int n = 0; n < 7; n++) tick_once();
        check("R3 toggled before stop", led_n, 1'b1);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        for (int n = 0; n < 20; n++) tick_once();
        check("R7 stopped stays dark", led_n, 1'b1);
        @(negedge clk); stop = 1'b1; load = 1'b1;
        @(negedge clk); stop = 1'b0; load = 1'b0;
        check("R7 stop beats load", led_n, 1'b1);
        for (int n = 0; n < 20; n++) tick_once();
        check("R7 still frozen", led_n, 1'b1);

        // R8: reload during counting
        set_bytes(10, 10, 10, 10);      // interval 30
        do_load();
        for (int n = 0; n < 20; n++) tick_once();
        set_bytes(2, 2, 2, 2);          // interval 6
        do_load();
        for (int n = 1; n <= 6; n++) begin
            tick_once();
            check("R8 restart with new interval", led_n, (n == 6) ? 1'b1 : 1'b0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule